// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table kept in ordinary memory. A client presents an address and an access kind (read or write) on a request port. The walker fetches a directory entry from a first-level table, whose 4 KB frame is given by a table-base input. That entry names the frame of a second-level table, and the walker fetches the leaf entry from it. It then checks the leaf's valid and permission bits. It answers with either the translated address or a fault code.

All table traffic uses one memory port that can read or write. The port carries a request that is held until an acknowledge pulse. A walk that is allowed to complete also keeps the leaf's status bits current. The "referenced" bit is set on every access and the "modified" bit on every write. The leaf is written back only when one of these bits actually changes. Only one walk runs at a time. Requests are taken only while the walker signals ready.

Top module: `xlat_walker`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req is 0.
- R2: The first memory access of a walk is a read (mem_we 0) at address {table_base[31:12], vaddr[31:22], 2'b00}, where table_base is sampled when the request is accepted.
- R3: The second access is a read at {dir[31:12], vaddr[21:12], 2'b00}, where dir is the 32-bit word returned by the first read.
- R4: Entry layout: bit 0 valid, bit 1 read permission, bit 2 write permission, bit 3 referenced, bit 4 modified, bits 31:12 frame number. A directory entry with bit 0 clear ends the walk with fault code 1 and no further memory access.
- R5: A leaf entry with bit 0 clear ends the walk with fault code 2 and no write-back.
- R6: A read to a leaf without bit 1, or a write to a leaf without bit 2, ends the walk with fault code 3 and no write-back.
- R7: A successful walk responds with fault code 0 and rsp_paddr = {leaf[31:12], vaddr[11:0]}.
- R8: The write-back word is the leaf with bit 3 set and, for a write access, bit 4 also set. It goes to the leaf's own address.
- R9: The leaf is written back only if that word differs from the leaf read. Otherwise the response follows the second read with no memory write.
- R10: While a walk is in flight, req_ready is 0 and any asserted req_valid is ignored.
- R11: rsp_valid is a one-cycle pulse, raised in the cycle after the acknowledge of the walk's last memory access. The walker is ready again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| table_base | input | 32 | Address of the first-level table (bits 31:12 used) |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 32 | Translated address (0 on fault) |
| rsp_fault_code | output | 2 | 0 ok, 1 directory invalid, 2 leaf invalid, 3 permission |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write access to memory |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge, completes the access |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The walk is exercised with first reads to a clean leaf, repeated reads to the same page, and first and repeated writes. These cases separate a write-back on a change of the referenced bit, a write-back on a change of the modified bit, and the case with no write-back. Invalid directory and leaf entries, together with read-only and write-only leaves, separate the three fault codes. They also show that no write-back follows a fault. The top table indices with an all-ones offset test the address splitting at its edges. Memory latencies of zero to three cycles, and a stray request during a walk, test the response timing and the single-walk rule.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  // entry bit positions (shared with software-built tables)
  localparam int PTE_V = 0;
  localparam int PTE_R = 1;
  localparam int PTE_W = 2;
  localparam int PTE_U = 3;
  localparam int PTE_D = 4;

  typedef enum logic [2:0] {
    S_IDLE, S_READ_L1, S_READ_L2, S_UPDATE, S_DONE, S_FAULT
  } walk_state_t;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_DIR  = 2'd1,
    FLT_LEAF = 2'd2,
    FLT_PERM = 2'd3
  } fault_t;
endpackage

// File: rtl/xlat_addr_gen.sv
module xlat_addr_gen #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int L1_W  = 10
) (
  input  logic [VA_W-1:0]       vaddr,
  input  logic [VA_W-OFF_W-1:0] base_frame,
  input  logic [VA_W-OFF_W-1:0] dir_frame,
  input  logic [VA_W-OFF_W-1:0] leaf_frame,
  output logic [VA_W-1:0]       l1_addr,
  output logic [VA_W-1:0]       l2_addr,
  output logic [VA_W-1:0]       paddr
);
  localparam int FRAME_W = VA_W - OFF_W;
  localparam int L2_W    = FRAME_W - L1_W;

  // a table entry is 4 bytes: frame base plus index scaled by 4
  function automatic logic [VA_W-1:0] entry_at(input logic [FRAME_W-1:0] frame,
                                               input logic [VA_W-1:0] idx);
    return {frame, {OFF_W{1'b0}}} | (idx << 2);
  endfunction

  function automatic logic [VA_W-1:0] join_pa(input logic [FRAME_W-1:0] frame,
                                              input logic [OFF_W-1:0] off);
    return {frame, off};
  endfunction

  assign l1_addr = entry_at(base_frame, VA_W'(vaddr[VA_W-1 -: L1_W]));
  assign l2_addr = entry_at(dir_frame,  VA_W'(vaddr[OFF_W +: L2_W]));
  assign paddr   = join_pa(leaf_frame, vaddr[OFF_W-1:0]);
endmodule

// File: rtl/xlat_pte_check.sv
module xlat_pte_check #(
  parameter int PTE_WID = 32
) (
  input  logic [PTE_WID-1:0] entry,
  input  logic               is_write,
  output logic               valid,
  output logic               allowed,
  output logic [PTE_WID-1:0] updated,
  output logic               needs_wb
);
  import xlat_pkg::*;

  function automatic logic [PTE_WID-1:0] mark(input logic [PTE_WID-1:0] e,
                                              input logic wr);
    logic [PTE_WID-1:0] r;
    r = e;
    r[PTE_U] = 1'b1;
    if (wr) r[PTE_D] = 1'b1;
    return r;
  endfunction

  assign valid    = entry[PTE_V];
  assign allowed  = is_write ? entry[PTE_W] : entry[PTE_R];
  assign updated  = mark(entry, is_write);
  assign needs_wb = (updated != entry);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int L1_W  = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] table_base,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            rsp_valid,
  output logic [VA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault_code,
  output logic            mem_req,
  output logic            mem_we,
  output logic [VA_W-1:0] mem_addr,
  output logic [VA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata
);
  import xlat_pkg::*;

  localparam int FRAME_W = VA_W - OFF_W;

  walk_state_t        state;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] dir_q;
  logic [VA_W-1:0]    pte_q;
  fault_t             fault_q;

  logic [VA_W-1:0] l1_addr, l2_addr, paddr;
  logic            rd_valid, rd_allowed, rd_needs_wb;
  logic [VA_W-1:0] rd_updated;
  logic            q_valid, q_allowed, q_needs_wb;
  logic [VA_W-1:0] q_updated;

  // named internal events
  logic ev_accept, ev_l1_ack, ev_l2_ack, ev_wb_ack;
  assign ev_accept = (state == S_IDLE) && req_valid;
  assign ev_l1_ack = (state == S_READ_L1) && mem_ack;
  assign ev_l2_ack = (state == S_READ_L2) && mem_ack;
  assign ev_wb_ack = (state == S_UPDATE) && mem_ack;

  xlat_addr_gen #(.VA_W(VA_W), .OFF_W(OFF_W), .L1_W(L1_W)) u_addr (
    .vaddr(va_q), .base_frame(base_q), .dir_frame(dir_q),
    .leaf_frame(pte_q[VA_W-1:OFF_W]),
    .l1_addr(l1_addr), .l2_addr(l2_addr), .paddr(paddr)
  );

  // decision on the leaf as it arrives
  xlat_pte_check #(.PTE_WID(VA_W)) u_chk_rd (
    .entry(mem_rdata), .is_write(wr_q), .valid(rd_valid), .allowed(rd_allowed),
    .updated(rd_updated), .needs_wb(rd_needs_wb)
  );

  // write-back word from the stored leaf
  xlat_pte_check #(.PTE_WID(VA_W)) u_chk_q (
    .entry(pte_q), .is_write(wr_q), .valid(q_valid), .allowed(q_allowed),
    .updated(q_updated), .needs_wb(q_needs_wb)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      dir_q   <= '0;
      pte_q   <= '0;
      fault_q <= FLT_NONE;
    end else begin
      unique case (state)
        S_IDLE: if (ev_accept) begin
          va_q    <= req_vaddr;
          wr_q    <= req_write;
          base_q  <= table_base[VA_W-1:OFF_W];
          fault_q <= FLT_NONE;
          state   <= S_READ_L1;
        end
        S_READ_L1: if (ev_l1_ack) begin
          dir_q <= mem_rdata[VA_W-1:OFF_W];
          if (!mem_rdata[PTE_V]) begin
            fault_q <= FLT_DIR;
            state   <= S_FAULT;
          end else begin
            state <= S_READ_L2;
          end
        end
        S_READ_L2: if (ev_l2_ack) begin
          pte_q <= mem_rdata;
          if (!rd_valid) begin
            fault_q <= FLT_LEAF;
            state   <= S_FAULT;
          end else if (!rd_allowed) begin
            fault_q <= FLT_PERM;
            state   <= S_FAULT;
          end else if (rd_needs_wb) begin
            state <= S_UPDATE;
          end else begin
            state <= S_DONE;
          end
        end
        S_UPDATE: if (ev_wb_ack) state <= S_DONE;
        S_DONE:   state <= S_IDLE;
        S_FAULT:  state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = (state == S_READ_L1) || (state == S_READ_L2) || (state == S_UPDATE);
    mem_we    = (state == S_UPDATE);
    mem_addr  = (state == S_READ_L1) ? l1_addr : l2_addr;
    mem_wdata = (state == S_UPDATE) ? q_updated : '0;
  end

  assign req_ready      = (state == S_IDLE);
  assign rsp_valid      = (state == S_DONE) || (state == S_FAULT);
  assign rsp_paddr      = (state == S_DONE) ? paddr : '0;
  assign rsp_fault_code = (state == S_FAULT) ? fault_q : FLT_NONE;

  // R10: an idle walker touches neither memory nor the response
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !rsp_valid));

  // R2: the access after acceptance is a read in the first-level table
  a_r2_first_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> (mem_req && !mem_we &&
                   mem_addr[VA_W-1:OFF_W] == $past(table_base[VA_W-1:OFF_W])));

  // R8: every write-back marks the page referenced, writes also modified
  a_r8_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[PTE_U] && (!wr_q || mem_wdata[PTE_D])));

  // R9: a write-back always changes the stored leaf
  a_r9_changes: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata != pte_q));

  // R6: no write-back to a leaf lacking validity or the needed permission
  a_r6_no_wb_on_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (pte_q[PTE_V] && (wr_q ? pte_q[PTE_W] : pte_q[PTE_R])));

  // R7: a successful translation keeps the page offset
  a_r7_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault_code == FLT_NONE) |-> (rsp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

  // R11: the response is a single-cycle pulse followed by ready
  a_r11_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));
endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] table_base = 32'h0001_0000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault_code;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int tests = 0;
  int fails = 0;
  int cycle = 0;
  int mem_lat = 0;
  int wait_cnt = 0;
  int last_ack_cycle = 0;

  logic [31:0] mem_model [logic [31:0]];
  logic [31:0] rd_log[$];
  logic [31:0] wa_log[$];
  logic [31:0] wd_log[$];

  always #10 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst_n(rst_n), .table_base(table_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault_code(rsp_fault_code), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    if (mem_model.exists(a)) return mem_model[a];
    return 32'h0;
  endfunction

  // memory responder, acts on falling edges
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack  <= 1'b0;
      wait_cnt <= 0;
    end else if (mem_req) begin
      if (wait_cnt >= mem_lat) begin
        if (mem_we) begin
          mem_model[mem_addr] = mem_wdata;
          wa_log.push_back(mem_addr);
          wd_log.push_back(mem_wdata);
          mem_rdata <= 32'h0;
        end else begin
          rd_log.push_back(mem_addr);
          mem_rdata <= rd_mem(mem_addr);
        end
        mem_ack <= 1'b1;
        last_ack_cycle = cycle;
      end else begin
        wait_cnt <= wait_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural expectation of one walk
  task automatic walk(input string tag, input logic [31:0] va, input logic wr,
                      input bit stray);
    logic [31:0] e1, e2, l1a, l2a, nw, exp_pa;
    logic [1:0]  exp_fc;
    logic [31:0] exp_rd[$];
    logic [31:0] exp_wa[$];
    logic [31:0] exp_wd[$];
    bit busy_ok;
    int n, rsp_cyc;
    l1a = {table_base[31:12], 12'h0} + {20'h0, va[31:22], 2'b00};
    e1 = rd_mem(l1a);
    exp_rd.push_back(l1a);
    exp_pa = 0;
    if (e1[0] == 1'b0) exp_fc = 2'd1;
    else begin
      l2a = {e1[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
      e2 = rd_mem(l2a);
      exp_rd.push_back(l2a);
      if (e2[0] == 1'b0) exp_fc = 2'd2;
      else if ((wr && !e2[2]) || (!wr && !e2[1])) exp_fc = 2'd3;
      else begin
        exp_fc = 2'd0;
        nw = e2 | 32'h8 | (wr ? 32'h10 : 32'h0);
        if (nw != e2) begin exp_wa.push_back(l2a); exp_wd.push_back(nw); end
        exp_pa = {e2[31:12], va[11:0]};
      end
    end
    rd_log.delete(); wa_log.delete(); wd_log.delete();
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    if (stray) begin
      req_vaddr = va ^ 32'h0040_0000;
    end else begin
      req_valid = 1'b0;
    end
    busy_ok = 1; n = 0;
    while (!rsp_valid && n < 100) begin
      if (req_ready) busy_ok = 0;
      @(negedge clk);
      req_valid = 1'b0;
      n++;
    end
    rsp_cyc = cycle;
    chk({tag, " R10 busy not ready"}, {31'h0, busy_ok}, 32'h1);
    chk({tag, " R11 response seen"}, {31'h0, rsp_valid}, 32'h1);
    chk({tag, " R11 response timing"}, rsp_cyc, last_ack_cycle + 1);
    chk({tag, " R4 R5 R6 fault code"}, {30'h0, rsp_fault_code}, {30'h0, exp_fc});
    chk({tag, " R7 paddr"}, rsp_paddr, exp_pa);
    chk({tag, " R2 R3 read count"}, rd_log.size(), exp_rd.size());
    foreach (exp_rd[i])
      if (i < rd_log.size()) chk({tag, " R2 R3 read address"}, rd_log[i], exp_rd[i]);
    chk({tag, " R9 write count"}, wa_log.size(), exp_wa.size());
    foreach (exp_wa[i])
      if (i < wa_log.size()) begin
        chk({tag, " R8 write address"}, wa_log[i], exp_wa[i]);
        chk({tag, " R8 write data"}, wd_log[i], exp_wd[i]);
      end
    @(negedge clk);
    chk({tag, " R11 pulse ends"}, {31'h0, rsp_valid}, 32'h0);
    chk({tag, " R11 ready again"}, {31'h0, req_ready}, 32'h1);
    repeat (2) @(negedge clk);
    chk({tag, " R10 no late access"}, {31'h0, mem_req}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // directory at 0x10000; second-level table at frame 0x00020
    mem_model[32'h0001_0004] = 32'h0002_0001;            // idx1 1 valid
    mem_model[32'h0001_0FFC] = 32'h0003_0001;            // idx1 1023 valid
    mem_model[32'h0002_0014] = 32'h1234_5007;            // idx2 5: V R W clean
    mem_model[32'h0002_0018] = 32'h2222_2006;            // idx2 6: not valid
    mem_model[32'h0002_001C] = 32'h3333_300B;            // idx2 7: V R used
    mem_model[32'h0002_0020] = 32'h4444_4005;            // idx2 8: V W only
    mem_model[32'h0003_0FFC] = 32'hFFFF_F01F;            // idx2 1023: all set
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", {31'h0, req_ready}, 32'h1);
    chk("R1 no response in reset", {31'h0, rsp_valid}, 32'h0);
    chk("R1 no memory in reset", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {31'h0, req_ready & ~mem_req & ~rsp_valid}, 32'h1);

    mem_lat = 0;
    walk("R8 first read marks used",  32'h0040_5ABC, 1'b0, 0);
    walk("R9 second read no writeback", 32'h0040_5123, 1'b0, 0);
    mem_lat = 2;
    walk("R8 first write marks dirty", 32'h0040_5FFF, 1'b1, 1);
    walk("R9 second write no writeback", 32'h0040_5000, 1'b1, 0);
    mem_lat = 1;
    walk("R4 directory invalid", 32'h0080_5000, 1'b0, 0);
    walk("R5 leaf invalid", 32'h0040_6010, 1'b0, 0);
    walk("R6 write to read-only", 32'h0040_7020, 1'b1, 0);
    walk("R6 read of read-only ok", 32'h0040_7020, 1'b0, 0);
    mem_lat = 3;
    walk("R6 read of write-only", 32'h0040_8444, 1'b0, 1);
    walk("R6 write of write-only", 32'h0040_8444, 1'b1, 0);
    walk("R3 top indices", 32'hFFFF_FFFF, 1'b1, 0);
    mem_lat = 0;
    table_base = 32'h0002_0ABC;
    walk("R2 base low bits ignored", 32'h0140_0004, 1'b0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule